// File: doc/BRIEF.md
# Idle-Locked Serial Descrambler

This block sits on the receive side of a 100 Mb/s twisted-pair link, after clock recovery and line decoding. It takes one scrambled bit per clock and recovers the clear stream. It uses an 11-bit key generator that is identical to the one in the transmitter. The block has no programmed seed. While the line carries idle, whose clear form is all ones, it builds the key directly from the received bits. It then checks that key against a long run of ones. Once the key has proved itself, the block locks, and from then on the key runs freely through frames of any content.

Two things end lock. The first is loss of signal detect. The second is an idle watchdog, which expects an idle pattern within a window measured in byte times. The window is long enough for a maximum-size frame and its neighbours. When lock ends, the block returns to acquisition.

The descrambled bit is presented serially. It is also packed into fixed-width parallel words for the next stage. A bypass control passes the received bits through unchanged, and acquisition keeps running underneath.

Top module: `idle_descrambler`

## Requirements
- R1: While `rstN` is low and on the first cycle after it rises, `locked`, `outBit`, `wordValid` and `wordOut` are all zero.
- R2: While locked, `outBit` equals the received bit XOR the key bit on the clock edge that samples that bit. The key bit is k = key[10] XOR key[8] (x^11 + x^9 + 1), and the key then shifts left, taking in k at bit 0. A clear stream scrambled by the same generator therefore comes out unchanged.
- R3: While unlocked, the key shifts left and takes in the inverted received bit. Starting from any state, a scrambled all-ones stream therefore reaches lock within 11 + LOCK_RUN bits.
- R4: `locked` rises on the edge that samples the LOCK_RUN-th consecutive descrambled one, counted with signal detect high, and never earlier.
- R5: A descrambled zero while unlocked restarts the run of ones. After that zero, lock cannot occur until LOCK_RUN further ones have been seen.
- R6: While locked, a bit is idle when it is a descrambled one that ends a run of at least IDLE_BITS ones. An idle bit restarts the watchdog. If WINDOW_BYTES*8 consecutive bits pass with no idle bit, `locked` falls on the edge of the last of them and acquisition restarts.
- R7: A non-idle burst one bit shorter than the window does not drop lock.
- R8: When `sigDet` is low on an edge, `locked` is low after that edge and the run of ones is held at zero.
- R9: With `bypass` high, `outBit` equals the received bit sampled on the same edge. Key tracking and lock are unaffected.
- R10: `wordValid` pulses once every WORD_W bits. With it, `wordOut` carries the last WORD_W values of `outBit`, oldest at the MSB and the value shown in the same cycle at the LSB.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one received bit per rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inBit | input | 1 | Scrambled received bit |
| sigDet | input | 1 | Signal present on the line |
| bypass | input | 1 | Pass received bits through without descrambling |
| outBit | output | 1 | Descrambled (or bypassed) bit, registered |
| wordOut | output | WORD_W | Parallel word of the last WORD_W output bits |
| wordValid | output | 1 | One-cycle strobe marking a new `wordOut` |
| locked | output | 1 | Key locked and descrambling valid |

## Verification
The bench builds the block with WINDOW_BYTES = 40, which gives a 320-bit window. This shortened window puts both outcomes of the watchdog within a short run: a 319-bit non-idle burst that keeps lock, and a 320-bit burst that drops it on its exact edge. LOCK_RUN, IDLE_BITS and WORD_W stay at 60, 10 and 5. This makes the lock edge, the restarted run after an injected zero, and the five-bit word packing the same as those of the default build.

// File: rtl/idle_descr_pkg.sv
package idle_descr_pkg;

  // Strobes from the lock controller to the key datapath.
  typedef struct packed {
    logic keyLoad;     // acquisition: key takes the inverted received bit
    logic keyAdvance;  // locked: key free-runs on its own feedback
  } descrCtl_t;

endpackage

// File: rtl/idle_descr_datapath.sv
module idle_descr_datapath
  import idle_descr_pkg::*;
#(
  parameter int KEY_W  = 11,
  parameter int TAP_HI = 10,
  parameter int TAP_LO = 8,
  parameter int WORD_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inBit,
  input  logic              bypass,
  input  descrCtl_t         ctl,
  output logic              plainBit,
  output logic              outBit,
  output logic [WORD_W-1:0] wordOut,
  output logic              wordValid
);

  localparam int CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(WORD_W - 1);

  logic [KEY_W-1:0]  keyReg;
  logic              keyBit;
  logic              outSel;
  logic [WORD_W-2:0] shiftReg;
  logic [WORD_W-1:0] nextWord;
  logic [CNT_W-1:0]  wordCnt;

  assign keyBit   = keyReg[TAP_HI] ^ keyReg[TAP_LO];
  assign plainBit = inBit ^ keyBit;
  assign outSel   = bypass ? inBit : plainBit;
  assign nextWord = {shiftReg, outSel};

  // Key register: learns from the line or runs free.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyReg <= '0;
    end else if (ctl.keyLoad) begin
      keyReg <= {keyReg[KEY_W-2:0], ~inBit};
    end else if (ctl.keyAdvance) begin
      keyReg <= {keyReg[KEY_W-2:0], keyBit};
    end
  end

  // Serial output and serial-to-parallel packing.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outBit    <= 1'b0;
      shiftReg  <= '0;
      wordCnt   <= '0;
      wordOut   <= '0;
      wordValid <= 1'b0;
    end else begin
      outBit   <= outSel;
      shiftReg <= nextWord[WORD_W-2:0];
      if (wordCnt == LAST_SLOT) begin
        wordCnt   <= '0;
        wordOut   <= nextWord;
        wordValid <= 1'b1;
      end else begin
        wordCnt   <= wordCnt + 1'b1;
        wordValid <= 1'b0;
      end
    end
  end

  assert_word_spacing_R10: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid);

  assert_word_tail_R10: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> wordOut[0] == outBit);

endmodule

// File: rtl/idle_descr_control.sv
module idle_descr_control
  import idle_descr_pkg::*;
#(
  parameter int LOCK_RUN     = 60,
  parameter int IDLE_BITS    = 10,
  parameter int WINDOW_BYTES = 4000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sigDet,
  input  logic      plainBit,
  output descrCtl_t ctl,
  output logic      locked
);

  localparam int WINDOW_BITS = WINDOW_BYTES * 8;
  localparam int RUN_W       = $clog2(LOCK_RUN + 1);
  localparam int WD_W        = $clog2(WINDOW_BITS);
  localparam logic [RUN_W-1:0] RUN_FULL  = RUN_W'(LOCK_RUN);
  localparam logic [RUN_W-1:0] RUN_LAST  = RUN_W'(LOCK_RUN - 1);
  localparam logic [RUN_W-1:0] IDLE_LAST = RUN_W'(IDLE_BITS - 1);
  localparam logic [WD_W-1:0]  WD_LAST   = WD_W'(WINDOW_BITS - 1);

  logic [RUN_W-1:0] onesRun;
  logic [WD_W-1:0]  wdCount;
  logic             idleSeen;

  assign idleSeen       = plainBit && (onesRun >= IDLE_LAST);
  assign ctl.keyLoad    = !locked;
  assign ctl.keyAdvance = locked;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      locked  <= 1'b0;
      onesRun <= '0;
      wdCount <= '0;
    end else if (!sigDet) begin
      locked  <= 1'b0;
      onesRun <= '0;
      wdCount <= '0;
    end else begin
      if (!plainBit)
        onesRun <= '0;
      else if (onesRun != RUN_FULL)
        onesRun <= onesRun + 1'b1;

      if (!locked) begin
        wdCount <= '0;
        if (plainBit && onesRun == RUN_LAST)
          locked <= 1'b1;
      end else if (idleSeen) begin
        wdCount <= '0;
      end else if (wdCount == WD_LAST) begin
        locked  <= 1'b0;
        onesRun <= '0;
        wdCount <= '0;
      end else begin
        wdCount <= wdCount + 1'b1;
      end
    end
  end

  assert_sigdet_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
    !sigDet |=> (!locked && onesRun == '0));

  assert_lock_after_run_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(onesRun) == RUN_LAST);

  assert_zero_restarts_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!locked && !plainBit) |=> onesRun == '0);

  assert_window_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    wdCount <= WD_LAST);

  assert_idle_clears_wd_R6: assert property (@(posedge clk) disable iff (!rstN)
    (locked && sigDet && idleSeen) |=> (locked && wdCount == '0));

endmodule

// File: rtl/idle_descrambler.sv
module idle_descrambler
  import idle_descr_pkg::*;
#(
  parameter int LOCK_RUN     = 60,
  parameter int IDLE_BITS    = 10,
  parameter int WINDOW_BYTES = 4000,
  parameter int WORD_W       = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inBit,
  input  logic              sigDet,
  input  logic              bypass,
  output logic              outBit,
  output logic [WORD_W-1:0] wordOut,
  output logic              wordValid,
  output logic              locked
);

  descrCtl_t ctl;
  logic      plainBit;

  idle_descr_datapath #(
    .KEY_W (11),
    .TAP_HI(10),
    .TAP_LO(8),
    .WORD_W(WORD_W)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .inBit    (inBit),
    .bypass   (bypass),
    .ctl      (ctl),
    .plainBit (plainBit),
    .outBit   (outBit),
    .wordOut  (wordOut),
    .wordValid(wordValid)
  );

  idle_descr_control #(
    .LOCK_RUN    (LOCK_RUN),
    .IDLE_BITS   (IDLE_BITS),
    .WINDOW_BYTES(WINDOW_BYTES)
  ) u_control (
    .clk     (clk),
    .rstN    (rstN),
    .sigDet  (sigDet),
    .plainBit(plainBit),
    .ctl     (ctl),
    .locked  (locked)
  );

  assert_bypass_passthru_R9: assert property (@(posedge clk) disable iff (!rstN)
    bypass |=> outBit == $past(inBit));

endmodule

// File: tb/idle_descrambler_tb.sv
`timescale 1ns/100ps
module idle_descrambler_tb;

  localparam int LOCK_RUN = 60;
  localparam int WIN_BITS = 40 * 8;
  localparam int WORD_W   = 5;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              inBit = 1'b0;
  logic              sigDet = 1'b1;
  logic              bypass = 1'b0;
  logic              outBit;
  logic [WORD_W-1:0] wordOut;
  logic              wordValid;
  logic              locked;

  int checks = 0;
  int fails  = 0;

  logic [10:0]       txKey = 11'h5A3;
  logic              lastIn;
  logic [WORD_W-1:0] hist = '0;
  int                sinceWord = 0;
  bit                seenWord = 0;

  localparam logic [7:0] DATA_VEC [16] = '{
    8'h55, 8'hD5, 8'h3C, 8'h00, 8'hA7, 8'h19, 8'hFE, 8'h01,
    8'h80, 8'h6B, 8'hC3, 8'h2E, 8'h90, 8'h4F, 8'h71, 8'hB8
  };

  always #2.5 clk = ~clk;

  idle_descrambler #(
    .LOCK_RUN(LOCK_RUN), .IDLE_BITS(10), .WINDOW_BYTES(40), .WORD_W(WORD_W)
  ) u_dut (
    .clk(clk), .rstN(rstN), .inBit(inBit), .sigDet(sigDet), .bypass(bypass),
    .outBit(outBit), .wordOut(wordOut), .wordValid(wordValid), .locked(locked)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Scramble one clear bit with the transmit-side generator, drive it,
  // let one edge pass and check the parallel word stream (R10).
  task automatic sendBit(input logic plain);
    logic k;
    k = txKey[10] ^ txKey[8];
    txKey = {txKey[9:0], k};
    lastIn = plain ^ k;
    inBit = lastIn;
    @(posedge clk);
    #1;
    hist = {hist[WORD_W-2:0], outBit};
    sinceWord++;
    if (wordValid) begin
      chk(wordOut === hist, "R10 word", int'(wordOut), int'(hist));
      if (seenWord) chk(sinceWord == WORD_W, "R10 spacing", sinceWord, WORD_W);
      seenWord = 1;
      sinceWord = 0;
    end
  endtask

  task automatic sendIdle(input int n);
    for (int i = 0; i < n; i++) sendBit(1'b1);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end

  initial begin
    int lockAt;
    repeat (3) @(posedge clk);
    #1;
    chk(locked == 0 && outBit == 0 && wordValid == 0 && wordOut == 0,
        "R1 in reset", int'(locked), 0);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    chk(locked == 0 && outBit == 0 && wordValid == 0 && wordOut == 0,
        "R1 after reset", int'(locked), 0);

    // R3/R4: acquisition from a zero key on scrambled idle.
    lockAt = 0;
    for (int i = 1; i <= 90; i++) begin
      sendBit(1'b1);
      if (i < LOCK_RUN) chk(!locked, "R4 no early lock", int'(locked), 0);
      if (locked && lockAt == 0) lockAt = i;
    end
    chk(lockAt != 0 && lockAt <= 11 + LOCK_RUN, "R3 lock latency", lockAt, 11 + LOCK_RUN);

    // R2: vector table of clear bytes, MSB first.
    sendIdle(20);
    foreach (DATA_VEC[v]) begin
      for (int b = 7; b >= 0; b--) begin
        sendBit(DATA_VEC[v][b]);
        chk(outBit == DATA_VEC[v][b], "R2 descramble", int'(outBit), int'(DATA_VEC[v][b]));
      end
    end
    chk(locked, "R2 lock held through data", int'(locked), 1);

    // R7/R6: non-idle burst against the window.
    sendIdle(20);
    for (int i = 1; i <= WIN_BITS; i++) begin
      sendBit(logic'((i - 1) % 2));
      if (i == WIN_BITS - 1) chk(locked, "R7 lock kept below window", int'(locked), 1);
      if (i == WIN_BITS) chk(!locked, "R6 lock dropped at window", int'(locked), 0);
    end
    lockAt = 0;
    for (int i = 1; i <= 100; i++) begin
      sendBit(1'b1);
      if (locked && lockAt == 0) lockAt = i;
    end
    chk(lockAt != 0 && lockAt <= 11 + LOCK_RUN, "R6 reacquire after timeout", lockAt, 11 + LOCK_RUN);

    // R8: signal detect loss.
    sendIdle(20);
    sigDet = 1'b0;
    sendBit(1'b1);
    chk(!locked, "R8 drop on sigDet low", int'(locked), 0);
    sigDet = 1'b1;
    for (int i = 1; i <= LOCK_RUN; i++) begin
      sendBit(1'b1);
      if (i == LOCK_RUN - 1) chk(!locked, "R4 one short of run", int'(locked), 0);
      if (i == LOCK_RUN) chk(locked, "R4 lock on run edge", int'(locked), 1);
    end

    // R5: a zero in the middle of acquisition.
    sigDet = 1'b0;
    sendBit(1'b1);
    sigDet = 1'b1;
    sendIdle(40);
    sendBit(1'b0);
    for (int i = 1; i <= LOCK_RUN - 1; i++) begin
      sendBit(1'b1);
      chk(!locked, "R5 run restarted by zero", int'(locked), 0);
    end
    lockAt = 0;
    for (int i = 1; i <= 100; i++) begin
      sendBit(1'b1);
      if (locked && lockAt == 0) lockAt = i;
    end
    chk(lockAt != 0, "R5 relock after zero", lockAt, 1);

    // R9: bypass passes the line through and keeps the key.
    sendIdle(20);
    bypass = 1'b1;
    for (int i = 0; i < 30; i++) begin
      sendBit(logic'(i % 3 == 0));
      chk(outBit == lastIn, "R9 bypass passthrough", int'(outBit), int'(lastIn));
    end
    chk(locked, "R9 lock kept in bypass", int'(locked), 1);
    bypass = 1'b0;
    sendIdle(20);
    for (int b = 7; b >= 0; b--) begin
      sendBit(DATA_VEC[2][b]);
      chk(outBit == DATA_VEC[2][b], "R9 key intact after bypass", int'(outBit), int'(DATA_VEC[2][b]));
    end

    summary();
    $finish;
  end

endmodule